// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple APB-style register bus with byte-wide data. Its data register occupies a window of addresses. Address bits [9:2] of each access form a per-pin mask. Software can therefore read or change any subset of pins in one bus access, with no read-modify-write. A read returns the level of each selected pin and zero for every other bit. A write updates only the selected output latch bits.

A direction register picks, pin by pin, whether the port drives the pin. The output-enable bus follows that register. The output pin bus always carries the latched output data. Input levels pass through a two-stage synchroniser before software can see them. A pin configured as an output reads back its own latched value. Every access finishes without wait states.

Top module: `gpmask_port`

## Requirements
- R1: After reset, the direction register reads 0x00, `pin_oe_o` is 0x00 and `pin_o` is 0x00.
- R2: A read with `paddr_i[11:10]` = 0 and `paddr_i[1:0]` = 0 reaches the data register. It returns each pin's level in the bits where mask `paddr_i[9:2]` is 1, and 0 in every bit where the mask is 0.
- R3: A data write sets each output latch bit whose mask bit is 1 to the matching `pwdata_i` bit. Each latch bit whose mask bit is 0 keeps its previous value.
- R4: Writing data `1 << n` to address `1 << (n+2)` drives pin n high. Writing data 0 to the same address drives it low. No other pin changes in either case.
- R5: The direction register is at byte address 0x400. A write stores `pwdata_i`, and a read returns the stored byte exactly. Bit n = 1 makes pin n an output.
- R6: `pin_oe_o` equals the direction register at all times. `pin_o` equals the output latch at all times.
- R7: A pin with direction 0 reads back its input level two clock edges after the input changes, and not after one edge. A pin with direction 1 reads back its latched output value.
- R8: An access is unmapped when its address is above 0x400, or when `paddr_i[1:0]` is nonzero. An unmapped read returns 0x00. An unmapped write changes neither register.
- R9: A write takes effect only on a clock edge where `psel_i`, `penable_i` and `pwrite_i` are all 1. A setup phase alone has no effect. `prdata_o` is 0 outside a read access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 8 | Write data |
| prdata_o | output | 8 | Read data, valid in the read access phase |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| pin_o | output | 8 | Latched output levels |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
The hardest case to reach from the ports is the synchroniser latency: showing that a pin change is invisible after one edge and visible after the second. The bench holds a read access phase open across both edges and changes the input on a falling edge, so `prdata_o` can be sampled between the edges. A second hard case is the per-bit merge on readback, where output and input pins are mixed. The bench programs a split direction byte, loads a known output pattern and applies a different input pattern, so that every bit's source is distinguishable in a single read.

// File: rtl/gpmask_pkg.sv
package gpmask_pkg;
    // Register that an access selects
    typedef enum logic [1:0] {
        GM_SEL_NONE = 2'd0,
        GM_SEL_DATA = 2'd1,
        GM_SEL_DIR  = 2'd2
    } gm_sel_e;
endpackage

// File: rtl/gpmask_decode.sv
module gpmask_decode
    import gpmask_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int ADDR_W     = 12,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output gm_sel_e             sel_o,
    output logic [NUM_PINS-1:0] mask_o
);
    localparam int MASK_LSB = 2;
    localparam int WIN_MSB  = MASK_LSB + NUM_PINS;
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

    logic aligned;
    logic in_window;

    always_comb begin
        aligned   = (addr_i[MASK_LSB-1:0] == '0);
        in_window = (addr_i[ADDR_W-1:WIN_MSB] == '0);
        mask_o    = addr_i[WIN_MSB-1:MASK_LSB];
        if (!aligned) begin
            sel_o = GM_SEL_NONE;
        end else if (in_window) begin
            sel_o = GM_SEL_DATA;
        end else if (addr_i == DIR_ADDR) begin
            sel_o = GM_SEL_DIR;
        end else begin
            sel_o = GM_SEL_NONE;
        end
    end
endmodule

// File: rtl/gpmask_sync.sv
module gpmask_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] stage1;
        logic [NUM_PINS-1:0] stage2;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.stage1 = pin_i;
        state_d.stage2 = state_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.stage2;
endmodule

// File: rtl/gpmask_outreg.sv
module gpmask_outreg #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] out_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] out;
    } outreg_t;

    outreg_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.out = (state_q.out & ~mask_i) | (wdata_i & mask_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_o = state_q.out;

    // R3: latch bits outside the mask survive a write
    a_r3_unmasked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ((state_q.out & ~$past(mask_i)) == ($past(state_q.out) & ~$past(mask_i))));

    // R3: bits inside the mask take the written data
    a_r3_masked_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ((state_q.out & $past(mask_i)) == ($past(wdata_i) & $past(mask_i))));
endmodule

// File: rtl/gpmask_dirreg.sv
module gpmask_dirreg #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] dir_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
    } dirreg_t;

    dirreg_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.dir = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dir_o = state_q.dir;

    // R5: direction holds unless written
    a_r5_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(state_q.dir));
endmodule

// File: rtl/gpmask_port.sv
module gpmask_port
    import gpmask_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int ADDR_W     = 12,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                psel_i,
    input  logic                penable_i,
    input  logic                pwrite_i,
    input  logic [ADDR_W-1:0]   paddr_i,
    input  logic [NUM_PINS-1:0] pwdata_i,
    output logic [NUM_PINS-1:0] prdata_o,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);
    gm_sel_e             sel;
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] out_lvl;
    logic [NUM_PINS-1:0] dir_lvl;
    logic [NUM_PINS-1:0] pin_level;
    logic                access;
    logic                rd_acc;
    logic                wr_acc;

    assign access = psel_i & penable_i;
    assign rd_acc = access & ~pwrite_i;
    assign wr_acc = access & pwrite_i;

    gpmask_decode #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .DIR_OFFSET(DIR_OFFSET)
    ) u_decode (
        .addr_i(paddr_i),
        .sel_o (sel),
        .mask_o(mask)
    );

    gpmask_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .sync_o(sync_lvl)
    );

    gpmask_outreg #(.NUM_PINS(NUM_PINS)) u_outreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(wr_acc && (sel == GM_SEL_DATA)),
        .mask_i (mask),
        .wdata_i(pwdata_i),
        .out_o  (out_lvl)
    );

    gpmask_dirreg #(.NUM_PINS(NUM_PINS)) u_dirreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_en_i(wr_acc && (sel == GM_SEL_DIR)),
        .wdata_i(pwdata_i),
        .dir_o  (dir_lvl)
    );

    // Per-pin readback source: own latch when driving, synchroniser otherwise
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_level
        assign pin_level[g] = dir_lvl[g] ? out_lvl[g] : sync_lvl[g];
    end

    always_comb begin
        prdata_o = '0;
        if (rd_acc) begin
            unique case (sel)
                GM_SEL_DATA: prdata_o = pin_level & mask;
                GM_SEL_DIR:  prdata_o = dir_lvl;
                default:     prdata_o = '0;
            endcase
        end
    end

    assign pin_o    = out_lvl;
    assign pin_oe_o = dir_lvl;

    // R2: unselected bits of a data read are zero
    a_r2_unmasked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_acc && (sel == GM_SEL_DATA)) |-> ((prdata_o & ~mask) == '0));

    // R8: unmapped reads return zero
    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psel_i && (sel == GM_SEL_NONE)) |-> (prdata_o == '0));

    // R8: unmapped writes leave both registers alone
    a_r8_unmapped_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && (sel == GM_SEL_NONE)) |=> ($stable(pin_o) && $stable(pin_oe_o)));

    // R9: a setup phase never changes the port
    a_r9_setup_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psel_i && !penable_i) |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/gpmask_port_tb_top.sv
`timescale 1ns/1ps
module gpmask_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpmask_port dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .psel_i   (psel),
        .penable_i(penable),
        .pwrite_i (pwrite),
        .paddr_i  (paddr),
        .pwdata_i (pwdata),
        .prdata_o (prdata),
        .pin_i    (pin_in),
        .pin_o    (pin_out),
        .pin_oe_o (pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        bus_read(12'h400, r);
        chk("R1 dir after reset", r, 8'h00);
        chk("R1 oe after reset", pin_oe, 8'h00);
        chk("R1 pin_o after reset", pin_out, 8'h00);
        #1 chk("R9 prdata idle", prdata, 8'h00);
    endtask

    task automatic t_direction;
        logic [7:0] r;
        bus_write(12'h400, 8'hA5);
        bus_read(12'h400, r);
        chk("R5 dir readback", r, 8'hA5);
        chk("R6 oe follows dir", pin_oe, 8'hA5);
    endtask

    task automatic t_masked_write;
        bus_write(12'h400, 8'hFF);
        bus_write(12'h3FC, 8'h5A);
        chk("R3 full-mask write", pin_out, 8'h5A);
        bus_write(12'h03C, 8'hF0);
        chk("R3 low-nibble mask write", pin_out, 8'h50);
    endtask

    task automatic t_single_pin;
        bus_write(12'h020, 8'h08);
        chk("R4 set pin 3", pin_out, 8'h58);
        bus_write(12'h040, 8'h00);
        chk("R4 clear pin 4", pin_out, 8'h48);
        bus_write(12'h200, 8'h00);
        chk("R4 clear pin 7 already low", pin_out, 8'h48);
    endtask

    task automatic t_masked_read;
        logic [7:0] r;
        bus_read(12'h030, r);
        chk("R2 read mask 0x0C", r, 8'h08);
        bus_read(12'h3FC, r);
        chk("R2 read full mask", r, 8'h48);
        bus_read(12'h000, r);
        chk("R2 read empty mask", r, 8'h00);
    endtask

    task automatic t_sync;
        logic [7:0] r;
        bus_write(12'h400, 8'h00);
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = 12'h3FC;
        pin_in = 8'h3C;
        @(negedge clk);
        #1 chk("R7 input not visible after one edge", prdata, 8'h00);
        @(negedge clk);
        #1 chk("R7 input visible after two edges", prdata, 8'h3C);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        bus_write(12'h400, 8'h0F);
        bus_read(12'h3FC, r);
        chk("R7 mixed output/input readback", r, 8'h38);
        chk("R6 pin_o holds latch while input", pin_out, 8'h48);
    endtask

    task automatic t_unmapped;
        logic [7:0] r;
        bus_write(12'h404, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_write(12'h021, 8'hFF);
        chk("R8 unmapped write keeps dir", pin_oe, 8'h0F);
        chk("R8 unmapped write keeps out", pin_out, 8'h48);
        bus_read(12'h404, r);
        chk("R8 read 0x404", r, 8'h00);
        bus_read(12'hFFC, r);
        chk("R8 read 0xFFC", r, 8'h00);
        bus_read(12'h3FD, r);
        chk("R8 read misaligned", r, 8'h00);
    endtask

    task automatic t_setup_only;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 8'hFF;
        @(negedge clk);
        paddr = 12'h400;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        chk("R9 setup-only keeps out", pin_out, 8'h48);
        chk("R9 setup-only keeps dir", pin_oe, 8'h0F);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_masked_write();
        t_single_pin();
        t_masked_read();
        t_sync();
        t_unmapped();
        t_setup_only();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule